// File: doc/BRIEF.md
# Multiprocessor UART Transmitter

This block serialises characters for an asynchronous serial link that several processors may share. Software, or a bus slave in front of this block, writes a character into a one-entry holding buffer. At the next bit-rate tick the character moves into a shift register, and the buffer is free again for the following character. The bit-rate tick comes from a divider outside the block. Every bit on the line lasts exactly one tick period. The buffer-empty flag and the transmitter-empty status tell the host when it may write and when the line has gone quiet.

The frame shape is set by static control inputs: 7 or 8 data bits, optional parity with odd or even sense, and one or two stop bits. A link protocol input selects one of two schemes for marking a frame as an address:
- Address-bit scheme: an extra bit follows the data and is counted in the parity.
- Idle-line scheme: an address frame is preceded by a long idle gap on the line.

A wake flag that the host writes tags the next frame as an address and clears itself when that frame is taken. A software reset input holds the engine idle. A loopback switch routes the serial output to the receive input of a neighbouring receiver.

Top module: `mpUartTx`

## Requirements
- R1: A frame is a low start bit, then the data bits with the least significant first, then the optional address bit, then the optional parity bit, then the stop bits at high level. Each bit lasts one tick period. The line is high whenever the transmitter is empty.
- R2: With `dataLen8`=0, seven data bits are sent and bit 7 of `holdOut` reads 0. With `dataLen8`=1, eight data bits are sent.
- R3: With `parityEn`=1, a parity bit follows the data. `parityEven`=1 makes the count of ones over the data, the address bit and the parity bit even. `parityEven`=0 makes that count odd. With `parityEn`=0, no parity bit is sent and `parityEven` has no effect.
- R4: `twoStop`=0 sends one stop bit and `twoStop`=1 sends two.
- R5: With `addrBitMode`=1, one extra bit follows the data. It is 1 for an address frame and 0 for a data frame, and it is included in the parity.
- R6: A write with `wakeWr`=1 sets the wake flag to `wakeVal`, and `wakePending` shows the flag. The flag is cleared in the cycle the frame leaves the holding buffer, so it marks exactly one frame.
- R7: With `addrBitMode`=0, a frame taken while the wake flag is set has at least 11 tick periods of high line before its start bit.
- R8: `bufEmptyFlag` is 1 after reset and is cleared by a buffer write. It is set again when the character moves into the shift register.
- R9: `txEmpty` is 1 when no frame is in progress and the buffer is empty, or while `swReset` is 1. Otherwise it is 0.
- R10: While `swReset`=1, the line is driven high, a frame in progress is abandoned, and buffer and wake writes are ignored. After the release, no frame is sent.
- R11: With `loopback`=1, `loopRx` follows `txLine`. With `loopback`=0, `loopRx` follows `rxPin`.
- R12: When the buffer is full at the end of a frame, the next start bit follows the last stop bit with no idle period. A buffer write in the same cycle as a transfer is kept, so the buffer stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| swReset | input | 1 | Software reset; holds the engine idle while 1 |
| bitTick | input | 1 | One-cycle pulse per bit period from the external divider |
| dataLen8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| parityEn | input | 1 | Enables the parity bit |
| parityEven | input | 1 | 1 = even parity, 0 = odd parity |
| twoStop | input | 1 | 1 = two stop bits, 0 = one stop bit |
| addrBitMode | input | 1 | 1 = address-bit scheme, 0 = idle-line scheme |
| wakeWr | input | 1 | Write strobe for the wake flag |
| wakeVal | input | 1 | Value written to the wake flag |
| bufWr | input | 1 | Write strobe for the holding buffer |
| bufWrData | input | 8 | Character written to the holding buffer |
| loopback | input | 1 | Routes the serial output to `loopRx` |
| rxPin | input | 1 | External receive line |
| txLine | output | 1 | Serial output line |
| loopRx | output | 1 | Receive input for the neighbouring receiver |
| holdOut | output | 8 | Read-back of the holding buffer |
| wakePending | output | 1 | Current value of the wake flag |
| bufEmptyFlag | output | 1 | Buffer-empty interrupt flag |
| txEmpty | output | 1 | Transmitter-empty status |

## Verification
Two events can land on the same clock edge. A bit tick can move the buffered character into the shift register in the cycle that a fresh buffer write arrives. Likewise, the last stop bit can finish while the next character is already waiting.

The bench provokes the first case by counting the tick phase. It writes one character just after a tick, then writes a second character exactly on the following tick. Both frames must then appear back to back, in order, and `bufEmptyFlag` must stay 0.

An idle-line address frame is queued behind a running frame, so the inserted gap is the only source of idle line. That gap is measured in whole bit periods by the frame monitor.

// File: rtl/mpUartTxPkg.sv
package mpUartTxPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_SEND = 2'd2
  } txStateT;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;   // write holding buffer
    logic load;      // move buffer into shift register
    logic startNow;  // drive the start bit
    logic shiftBit;  // advance to next frame bit
    logic idleLine;  // force the line high
  } txStrobeT;

endpackage

// File: rtl/mpUartTxCtrl.sv
module mpUartTxCtrl
  import mpUartTxPkg::*;
#(
  parameter int LEN_W     = 4,
  parameter int IDLE_BITS = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swReset,
  input  logic             bitTick,
  input  logic             addrBitMode,
  input  logic             wakeWr,
  input  logic             wakeVal,
  input  logic             bufWr,
  input  logic [LEN_W-1:0] frameLen,
  output txStrobeT         strb,
  output logic             bufFull,
  output logic             wakePending,
  output logic             txEmpty
);

  localparam int GAP_W = (IDLE_BITS > 1) ? $clog2(IDLE_BITS) : 1;

  txStateT          state, nState;
  logic [LEN_W-1:0] bitsLeft, nBits;
  logic [GAP_W-1:0] gapCnt, nGap;
  logic             wake;

  always_comb begin
    logic beginFrame;
    strb       = '0;
    nState     = state;
    nBits      = bitsLeft;
    nGap       = gapCnt;
    beginFrame = 1'b0;
    strb.capture = bufWr && !swReset;
    if (swReset) begin
      strb.idleLine = 1'b1;
      nState        = ST_IDLE;
    end else if (bitTick) begin
      unique case (state)
        ST_IDLE: beginFrame = bufFull;
        ST_GAP: begin
          if (gapCnt == '0) begin
            strb.startNow = 1'b1;
            nState        = ST_SEND;
          end else begin
            nGap = gapCnt - 1'b1;
          end
        end
        ST_SEND: begin
          if (bitsLeft != '0) begin
            strb.shiftBit = 1'b1;
            nBits         = bitsLeft - 1'b1;
          end else if (bufFull) begin
            beginFrame = 1'b1;
          end else begin
            strb.idleLine = 1'b1;
            nState        = ST_IDLE;
          end
        end
        default: nState = ST_IDLE;
      endcase
    end
    if (beginFrame) begin
      strb.load = 1'b1;
      nBits     = frameLen;
      if (!addrBitMode && wake) begin
        strb.idleLine = 1'b1;
        nGap          = GAP_W'(IDLE_BITS - 1);
        nState        = ST_GAP;
      end else begin
        strb.startNow = 1'b1;
        nState        = ST_SEND;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitsLeft <= '0;
      gapCnt   <= '0;
      bufFull  <= 1'b0;
      wake     <= 1'b0;
    end else begin
      state    <= nState;
      bitsLeft <= nBits;
      gapCnt   <= nGap;
      if (swReset)           bufFull <= 1'b0;
      else if (strb.capture) bufFull <= 1'b1;
      else if (strb.load)    bufFull <= 1'b0;
      if (swReset)           wake <= 1'b0;
      else if (wakeWr)       wake <= wakeVal;
      else if (strb.load)    wake <= 1'b0;
    end
  end

  assign wakePending = wake;
  assign txEmpty     = swReset || (state == ST_IDLE && !bufFull);

  // R6: the wake flag is consumed by the frame it tags
  p_wake_oneshot_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !wakeWr) |=> !wakePending);

  // R7: the gap never shifts frame bits
  p_gap_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP && !swReset && bitTick && gapCnt != '0) |=> (state == ST_GAP));

endmodule

// File: rtl/mpUartTxPath.sv
module mpUartTxPath
  import mpUartTxPkg::*;
#(
  parameter int MAX_DATA = 8,
  parameter int SH_W     = MAX_DATA + 4,
  parameter int LEN_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobeT            strb,
  input  logic                dataLen8,
  input  logic                parityEn,
  input  logic                parityEven,
  input  logic                twoStop,
  input  logic                addrBitMode,
  input  logic                wakeBit,
  input  logic [MAX_DATA-1:0] wrData,
  output logic [LEN_W-1:0]    frameLen,
  output logic [MAX_DATA-1:0] holdData,
  output logic                txLine
);

  logic [SH_W-1:0]     shReg, nextSh;
  logic [MAX_DATA-1:0] capData;

  // top data bit only survives in long-character mode
  for (genvar g = 0; g < MAX_DATA; g++) begin : gCapMask
    if (g == MAX_DATA - 1) begin : gTop
      assign capData[g] = wrData[g] & dataLen8;
    end else begin : gLow
      assign capData[g] = wrData[g];
    end
  end

  // frame bits after the start bit, LSB first
  always_comb begin
    logic [LEN_W-1:0] idx;
    logic             par;
    nextSh = '0;
    idx    = '0;
    par    = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < MAX_DATA - 1 || dataLen8) begin
        nextSh[idx] = holdData[i];
        par         = par ^ holdData[i];
        idx         = idx + 1'b1;
      end
    end
    if (addrBitMode) begin
      nextSh[idx] = wakeBit;
      par         = par ^ wakeBit;
      idx         = idx + 1'b1;
    end
    if (parityEn) begin
      nextSh[idx] = parityEven ? par : ~par;
      idx         = idx + 1'b1;
    end
    nextSh[idx] = 1'b1;
    idx         = idx + 1'b1;
    if (twoStop) begin
      nextSh[idx] = 1'b1;
      idx         = idx + 1'b1;
    end
    frameLen = idx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
      shReg    <= '0;
      txLine   <= 1'b1;
    end else begin
      if (strb.capture) holdData <= capData;
      if (strb.load)          shReg <= nextSh;
      else if (strb.shiftBit) shReg <= {1'b0, shReg[SH_W-1:1]};
      if (strb.idleLine)      txLine <= 1'b1;
      else if (strb.startNow) txLine <= 1'b0;
      else if (strb.shiftBit) txLine <= shReg[0];
    end
  end

  // R2: a short-character write never sets the unused top bit
  p_short_msb_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !dataLen8) |=> !holdData[MAX_DATA-1]);

endmodule

// File: rtl/mpUartTx.sv
module mpUartTx
  import mpUartTxPkg::*;
#(
  parameter int MAX_DATA  = 8,
  parameter int IDLE_BITS = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                swReset,
  input  logic                bitTick,
  input  logic                dataLen8,
  input  logic                parityEn,
  input  logic                parityEven,
  input  logic                twoStop,
  input  logic                addrBitMode,
  input  logic                wakeWr,
  input  logic                wakeVal,
  input  logic                bufWr,
  input  logic [MAX_DATA-1:0] bufWrData,
  input  logic                loopback,
  input  logic                rxPin,
  output logic                txLine,
  output logic                loopRx,
  output logic [MAX_DATA-1:0] holdOut,
  output logic                wakePending,
  output logic                bufEmptyFlag,
  output logic                txEmpty
);

  localparam int SH_W  = MAX_DATA + 4;
  localparam int LEN_W = $clog2(SH_W + 1);

  txStrobeT         strb;
  logic [LEN_W-1:0] frameLen;
  logic             bufFull;

  mpUartTxCtrl #(.LEN_W(LEN_W), .IDLE_BITS(IDLE_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .swReset(swReset), .bitTick(bitTick),
    .addrBitMode(addrBitMode), .wakeWr(wakeWr), .wakeVal(wakeVal),
    .bufWr(bufWr), .frameLen(frameLen), .strb(strb), .bufFull(bufFull),
    .wakePending(wakePending), .txEmpty(txEmpty)
  );

  mpUartTxPath #(.MAX_DATA(MAX_DATA), .SH_W(SH_W), .LEN_W(LEN_W)) i_path (
    .clk(clk), .rstN(rstN), .strb(strb), .dataLen8(dataLen8),
    .parityEn(parityEn), .parityEven(parityEven), .twoStop(twoStop),
    .addrBitMode(addrBitMode), .wakeBit(wakePending), .wrData(bufWrData),
    .frameLen(frameLen), .holdData(holdOut), .txLine(txLine)
  );

  assign bufEmptyFlag = !bufFull;
  assign loopRx       = loopback ? txLine : rxPin;

  // R10: software reset parks the line and reports empty
  p_swrst_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> (txLine && txEmpty && bufEmptyFlag));

  // R8: an accepted write always leaves the buffer occupied
  p_write_clears_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (bufWr && !swReset) |=> !bufEmptyFlag);

  // R9: waiting data means the transmitter is not empty
  p_busy_not_empty_r9: assert property (@(posedge clk) disable iff (!rstN || swReset)
    !bufEmptyFlag |-> !txEmpty);

  // R1: an empty transmitter keeps the line at mark level
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !swReset) |-> txLine);

endmodule

// File: tb/test_mpUartTx.sv
module test_mpUartTx;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;
  localparam int GAP_MIN    = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swReset = 1'b1;
  logic bitTick = 1'b0;
  logic dataLen8 = 1'b1, parityEn = 1'b0, parityEven = 1'b0, twoStop = 1'b0;
  logic addrBitMode = 1'b0, wakeWr = 1'b0, wakeVal = 1'b0;
  logic bufWr = 1'b0;
  logic [7:0] bufWrData = 8'h00;
  logic loopback = 1'b0, rxPin = 1'b1;
  logic txLine, loopRx, wakePending, bufEmptyFlag, txEmpty;
  logic [7:0] holdOut;

  mpUartTx i_mpUartTx (
    .clk(clk), .rstN(rstN), .swReset(swReset), .bitTick(bitTick),
    .dataLen8(dataLen8), .parityEn(parityEn), .parityEven(parityEven),
    .twoStop(twoStop), .addrBitMode(addrBitMode), .wakeWr(wakeWr),
    .wakeVal(wakeVal), .bufWr(bufWr), .bufWrData(bufWrData),
    .loopback(loopback), .rxPin(rxPin), .txLine(txLine), .loopRx(loopRx),
    .holdOut(holdOut), .wakePending(wakePending),
    .bufEmptyFlag(bufEmptyFlag), .txEmpty(txEmpty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int tc = 0;

  // scoreboard queues
  logic [15:0] expBitsQ[$];
  int          expLenQ[$];
  bit          expGapQ[$];
  string       expTagQ[$];

  bit monEn = 1'b0;
  bit inFrame = 1'b0;
  int pos = 0;
  int idleRun = 0;
  logic [15:0] curBits;
  logic wkModel = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // tick generator and frame monitor, both on the falling edge
  always @(negedge clk) begin
    if (!rstN) tc = 0;
    else tc = (tc == DIV-1) ? 0 : tc + 1;
    bitTick = rstN && (tc == 0);
    if (monEn && tc == DIV/2) begin
      if (!inFrame) begin
        if (txLine == 1'b0) begin
          if (expTagQ.size() == 0) begin
            checks++; failures++;
            $display("FAIL R10 unexpected start bit actual=0 expected=1");
          end else begin
            inFrame = 1'b1;
            curBits = '0;
            pos = 1;
            if (expGapQ[0]) begin
              checks++;
              if (idleRun < GAP_MIN) begin
                failures++;
                $display("FAIL R7 idle gap actual=%0d expected>=%0d", idleRun, GAP_MIN);
              end
            end
          end
        end else idleRun++;
      end else begin
        curBits[pos] = txLine;
        pos++;
        if (pos == expLenQ[0]) begin
          checks++;
          if (curBits !== expBitsQ[0]) begin
            failures++;
            $display("FAIL %s frame actual=%b expected=%b", expTagQ[0], curBits, expBitsQ[0]);
          end
          void'(expBitsQ.pop_front());
          void'(expLenQ.pop_front());
          void'(expGapQ.pop_front());
          void'(expTagQ.pop_front());
          inFrame = 1'b0;
          idleRun = 0;
        end
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  // expected frame built from the requirement text
  task automatic pushExp(input logic [7:0] d, input string tag);
    logic [15:0] v = '0;
    int n = 1;
    logic p = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < 7 || dataLen8) begin v[n] = d[i]; p ^= d[i]; n++; end
    end
    if (addrBitMode) begin v[n] = wkModel; p ^= wkModel; n++; end
    if (parityEn) begin v[n] = parityEven ? p : ~p; n++; end
    v[n] = 1'b1; n++;
    if (twoStop) begin v[n] = 1'b1; n++; end
    expBitsQ.push_back(v);
    expLenQ.push_back(n);
    expGapQ.push_back(!addrBitMode && wkModel);
    expTagQ.push_back(tag);
    wkModel = 1'b0;
  endtask

  task automatic writeRaw(input logic [7:0] d);
    bufWr = 1'b1; bufWrData = d;
    step();
    bufWr = 1'b0;
  endtask

  task automatic sendChar(input logic [7:0] d, input string tag);
    while (!bufEmptyFlag) step();
    pushExp(d, tag);
    writeRaw(d);
  endtask

  task automatic setWake(input logic v);
    wakeWr = 1'b1; wakeVal = v;
    step();
    wakeWr = 1'b0;
    wkModel = v;
  endtask

  task automatic waitIdle();
    step();
    while (!(txEmpty && expTagQ.size() == 0 && !inFrame)) step();
  endtask

  task automatic waitStart();
    while (txLine) step();
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    // reset state, software reset asserted from power-up
    chk(txEmpty == 1'b1, "R9 empty under swReset", txEmpty, 1);
    chk(bufEmptyFlag == 1'b1, "R8 flag after reset", bufEmptyFlag, 1);
    chk(txLine == 1'b1, "R10 line high under swReset", txLine, 1);
    swReset = 1'b0;
    monEn = 1'b1;
    step();

    // R1: plain 8N1 frames
    sendChar(8'hA5, "R1 8N1 A5");
    chk(bufEmptyFlag == 1'b0, "R8 flag cleared by write", bufEmptyFlag, 0);
    chk(txEmpty == 1'b0, "R9 not empty with data", txEmpty, 0);
    waitStart();
    step();
    chk(bufEmptyFlag == 1'b1, "R8 flag set on transfer", bufEmptyFlag, 1);
    sendChar(8'h3C, "R1 8N1 3C");
    waitIdle();
    chk(txEmpty == 1'b1, "R9 empty after frames", txEmpty, 1);

    // R12: write coinciding with a transfer
    while (tc != 3) step();
    pushExp(8'h96, "R12 first of pair");
    writeRaw(8'h96);
    while (tc != 0) step();
    pushExp(8'h5A, "R12 second of pair");
    writeRaw(8'h5A);
    chk(bufEmptyFlag == 1'b0, "R12 buffer kept full", bufEmptyFlag, 0);
    chk(txLine == 1'b0, "R12 first frame started", txLine, 0);
    waitIdle();

    // R2: 7-bit characters
    dataLen8 = 1'b0;
    sendChar(8'hD3, "R2 seven bits D3");
    chk(holdOut == 8'h53, "R2 top bit reads zero", holdOut, 8'h53);
    sendChar(8'h7F, "R2 seven bits 7F");
    waitIdle();
    dataLen8 = 1'b1;

    // R3: parity sense, and sense ignored when disabled
    parityEn = 1'b1; parityEven = 1'b1;
    sendChar(8'h07, "R3 even parity");
    waitIdle();
    parityEven = 1'b0;
    sendChar(8'h07, "R3 odd parity");
    sendChar(8'h00, "R3 odd parity zero");
    waitIdle();
    parityEn = 1'b0; parityEven = 1'b1;
    sendChar(8'h07, "R3 parity off sense ignored");
    waitIdle();
    parityEven = 1'b0;

    // R4: two stop bits, back to back
    twoStop = 1'b1;
    sendChar(8'hFF, "R4 two stops FF");
    sendChar(8'h00, "R4 two stops 00");
    waitIdle();
    twoStop = 1'b0;

    // R5 and R6: address-bit scheme
    addrBitMode = 1'b1; parityEn = 1'b1; parityEven = 1'b1;
    setWake(1'b1);
    chk(wakePending == 1'b1, "R6 wake set", wakePending, 1);
    sendChar(8'h41, "R5 address frame");
    waitStart();
    step();
    chk(wakePending == 1'b0, "R6 wake consumed", wakePending, 0);
    sendChar(8'h41, "R5 data frame");
    waitIdle();
    parityEn = 1'b0;
    setWake(1'b1);
    sendChar(8'h80, "R5 address no parity");
    waitIdle();

    // R7: idle-line scheme, address frame queued behind a running frame
    addrBitMode = 1'b0; parityEven = 1'b0;
    sendChar(8'h11, "R7 lead data frame");
    waitStart();
    step();
    setWake(1'b1);
    sendChar(8'h22, "R7 address after gap");
    waitIdle();
    chk(wakePending == 1'b0, "R6 wake consumed idle-line", wakePending, 0);

    // R11: loopback routing
    loopback = 1'b1; rxPin = 1'b0;
    step();
    chk(loopRx == 1'b1, "R11 loopback idle", loopRx, 1);
    loopback = 1'b0;
    step();
    chk(loopRx == 1'b0, "R11 external path", loopRx, 0);
    loopback = 1'b1; rxPin = 1'b1;
    sendChar(8'h00, "R11 loopback frame");
    waitStart();
    chk(loopRx == 1'b0, "R11 loopback follows start", loopRx, 0);
    waitIdle();
    loopback = 1'b0;

    // R10: software reset mid-frame
    monEn = 1'b0;
    writeRaw(8'h00);
    waitStart();
    repeat (2*DIV) step();
    swReset = 1'b1;
    step();
    chk(txLine == 1'b1, "R10 line forced high", txLine, 1);
    chk(txEmpty == 1'b1, "R10 empty in reset", txEmpty, 1);
    setWake(1'b1);
    wkModel = 1'b0;
    writeRaw(8'h0F);
    chk(bufEmptyFlag == 1'b1, "R10 write ignored", bufEmptyFlag, 1);
    chk(wakePending == 1'b0, "R10 wake write ignored", wakePending, 0);
    swReset = 1'b0;
    idleRun = 0;
    monEn = 1'b1;
    repeat (4*DIV) step();
    chk(txEmpty == 1'b1, "R10 nothing sent after release", txEmpty, 1);
    chk(txLine == 1'b1, "R10 line idle after release", txLine, 1);

    chk(expTagQ.size() == 0, "R1 all frames seen", expTagQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule